// File: doc/BRIEF.md
# Write-Path ECC Fault Injector

This block sits on the write data path of a memory controller, ahead of the ECC check logic. Its job is to corrupt one write beat on purpose so that the error detection and correction downstream can be exercised. Each write beat carries one 16-byte quadrant of a 64-byte line. That beat is laid out as nine 16-bit lanes: eight data words and one ECC check word.

Software reaches the block through two 32-bit registers on a simple configuration port. A selector register picks the injection array and the target quadrant. A data port holds three settings: a lane mask, a flip vector, and a set of request bits. Setting the write-request bit arms the block. The next write beat that targets the chosen quadrant then has the flip vector XORed into every masked lane, and the block clears the request bit by itself. Software polls the data port until that bit reads back as zero. Injection can happen only while the external ECC enable input is high.

Top module: `ecc_fault_injector`

## Requirements
- R1: After reset, both registers read as zero, no request is pending, and write beats pass through unchanged with `inject_hit` low.
- R2: The selector register (`cfg_sel`=0) stores the array select in bits 31:28 and the quadrant index in bits 2:1. It reads back exactly those bits, with every other bit zero. The injection array is selected when bits 31:28 equal 0x8.
- R3: While the injection array is selected, a data port write (`cfg_sel`=1) stores four fields: the lane mask in bits 28:20, the flip vector in bits 15:0, the error-enable bit in bit 18 and the read-request bit in bit 16. A data port read returns all of these fields, together with the live write-request bit in bit 17.
- R4: A data port write with bit 17 set, a nonzero mask and a nonzero vector arms injection, and bit 17 then reads back as 1. A data port write with bit 17 clear disarms injection.
- R5: A data port write whose lane mask or flip vector is zero leaves the write-request bit clear, even when bit 17 is set.
- R6: While the array select is not 0x8, data port writes change nothing, and data port reads return zero.
- R7: When the block is armed and `ecc_enable` is high, a write beat to the selected quadrant leaves the block in the same cycle with the vector XORed into every lane i whose mask bit i is set. Lane i occupies bits 16i+15:16i, and lane 8 is the ECC word. Unmasked lanes pass through unchanged.
- R8: The write-request bit clears on the clock edge that ends the corrupted beat. Later beats pass through unchanged.
- R9: A write beat to any other quadrant passes through unchanged and leaves the request pending.
- R10: While `ecc_enable` is low, no beat is corrupted and a pending request stays pending. The request fires once the enable returns high.
- R11: `inject_hit` is high exactly during a beat that is being corrupted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 = array selector, 1 = data port |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the register picked by `cfg_sel` |
| ecc_enable | input | 1 | Memory ECC enabled; gates injection |
| mem_wr_valid | input | 1 | Write beat valid |
| mem_wr_quad | input | 2 | Quadrant index of the write beat |
| mem_wr_data | input | 144 | Write beat: 8 data lanes and 1 ECC lane |
| mem_out_data | output | 144 | Write beat after optional corruption |
| inject_hit | output | 1 | This beat is being corrupted |

## Verification
The assertions check four rules on every cycle. An output beat that differs from its input only ever appears while a request is armed, the enable is high and a beat is valid. A fired request is gone on the next cycle, and an unfired one stays. Writes with a zero mask or vector, or with the array deselected, never arm anything. Data port reads are zero while the array is deselected. Only the bench scenarios can show that the right lanes flip with the right vector, and that register fields read back in their positions. They also show that a beat to another quadrant leaves the request for a later beat, and that a request held back by a low enable fires once the enable returns.

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector #(
  parameter int LANE_W     = 16,
  parameter int DATA_LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_wr,
  input  logic                          cfg_sel,
  input  logic [31:0]                   cfg_wdata,
  output logic [31:0]                   cfg_rdata,
  input  logic                          ecc_enable,
  input  logic                          mem_wr_valid,
  input  logic [1:0]                    mem_wr_quad,
  input  logic [(DATA_LANES+1)*LANE_W-1:0] mem_wr_data,
  output logic [(DATA_LANES+1)*LANE_W-1:0] mem_out_data,
  output logic                          inject_hit
);
  localparam int LANES    = DATA_LANES + 1;
  localparam int MASK_LSB = 20;
  localparam int MASK_MSB = MASK_LSB + LANES - 1;
  localparam logic [3:0] ARRAY_ID = 4'h8;

  logic [3:0]        arr_sel;
  logic [1:0]        tgt_quad;
  logic [LANES-1:0]  lane_mask;
  logic [LANE_W-1:0] flip_vec;
  logic              err_en, rd_req, wr_req;

  logic array_on, dp_wr, arm_ok;
  assign array_on = (arr_sel == ARRAY_ID);
  assign dp_wr    = cfg_wr & cfg_sel & array_on;
  assign arm_ok   = cfg_wdata[17] & (|cfg_wdata[MASK_MSB:MASK_LSB]) & (|cfg_wdata[LANE_W-1:0]);
  assign inject_hit = mem_wr_valid & wr_req & ecc_enable & (mem_wr_quad == tgt_quad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_sel   <= '0;
      tgt_quad  <= '0;
      lane_mask <= '0;
      flip_vec  <= '0;
      err_en    <= 1'b0;
      rd_req    <= 1'b0;
      wr_req    <= 1'b0;
    end else begin
      if (cfg_wr && !cfg_sel) begin
        arr_sel  <= cfg_wdata[31:28];
        tgt_quad <= cfg_wdata[2:1];
      end
      if (dp_wr) begin
        lane_mask <= cfg_wdata[MASK_MSB:MASK_LSB];
        flip_vec  <= cfg_wdata[LANE_W-1:0];
        err_en    <= cfg_wdata[18];
        rd_req    <= cfg_wdata[16];
        wr_req    <= arm_ok;
      end else if (inject_hit) begin
        wr_req <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mem_out_data[i*LANE_W +: LANE_W] =
      mem_wr_data[i*LANE_W +: LANE_W] ^ ({LANE_W{inject_hit & lane_mask[i]}} & flip_vec);
  end

  logic [31:0] addr_view, port_view;
  always_comb begin
    addr_view        = '0;
    addr_view[31:28] = arr_sel;
    addr_view[2:1]   = tgt_quad;
    port_view        = '0;
    port_view[MASK_MSB:MASK_LSB] = lane_mask;
    port_view[18]    = err_en;
    port_view[17]    = wr_req;
    port_view[16]    = rd_req;
    port_view[LANE_W-1:0] = flip_vec;
  end

  assign cfg_rdata = cfg_sel ? (array_on ? port_view : 32'h0) : addr_view;

  assert_fire_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inject_hit && !dp_wr |=> !wr_req);
  assert_pending_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !inject_hit && !dp_wr |=> wr_req);
  assert_zero_field_no_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr && (cfg_wdata[MASK_MSB:MASK_LSB] == '0 || cfg_wdata[LANE_W-1:0] == '0) |=> !wr_req);
  assert_deselected_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_sel && !array_on && !inject_hit |=> $stable(wr_req));
  assert_deselected_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel && !array_on |-> cfg_rdata == 32'h0);
  assert_gated_corruption_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_out_data != mem_wr_data |-> ecc_enable && wr_req && mem_wr_valid);
endmodule

// File: tb/test_ecc_fault_injector.sv
`timescale 1ns/1ps
module test_ecc_fault_injector;
  localparam int W = 144;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic ecc_enable = 0, mem_wr_valid = 0;
  logic [1:0] mem_wr_quad = '0;
  logic [W-1:0] mem_wr_data = '0, mem_out_data;
  logic inject_hit;
  int checks = 0, errors = 0;

  logic [W-1:0] exp_q[$];
  logic         hit_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  ecc_fault_injector i_ecc_fault_injector (.*);

  function automatic logic [W-1:0] corrupt(logic [W-1:0] d, logic [8:0] m, logic [15:0] v);
    for (int i = 0; i < 9; i++) if (m[i]) d[i*16 +: 16] ^= v;
    return d;
  endfunction

  always @(negedge clk) if (mem_wr_valid && exp_q.size() > 0) begin
    logic [W-1:0] e; logic h; string t;
    e = exp_q.pop_front(); h = hit_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (mem_out_data !== e) begin
      errors++; $display("FAIL %s data: actual %h expected %h", t, mem_out_data, e);
    end
    checks++;
    if (inject_hit !== h) begin
      errors++; $display("FAIL %s hit: actual %b expected %b", t, inject_hit, h);
    end
  end

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    @(posedge clk); #1; cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1; cfg_wr = 0;
  endtask

  task automatic cfg_check(input logic sel, input logic [31:0] e, input string t);
    cfg_sel = sel; @(negedge clk);
    checks++;
    if (cfg_rdata !== e) begin
      errors++; $display("FAIL %s read: actual %h expected %h", t, cfg_rdata, e);
    end
  endtask

  task automatic beat(input logic [1:0] q, input logic [W-1:0] d, input logic [W-1:0] e,
                      input logic h, input string t);
    @(posedge clk); #1;
    mem_wr_valid = 1; mem_wr_quad = q; mem_wr_data = d;
    exp_q.push_back(e); hit_q.push_back(h); tag_q.push_back(t);
    @(posedge clk); #1; mem_wr_valid = 0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] d1, d2;
    logic [31:0] dp;
    d1 = {9{16'h1234}} ^ {16'h0F0F, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210};
    d2 = {144{1'b1}} ^ d1;
    repeat (3) @(posedge clk); #1; rst_n = 1;
    cfg_check(0, 32'h0, "R1 selector");
    cfg_check(1, 32'h0, "R1 port");
    ecc_enable = 1;
    beat(0, d1, d1, 0, "R1 passthrough");

    cfg_write(0, 32'hFFFF_FFF4 & 32'h8000_0004 | 32'h0000_0F00 | 32'h8000_0004);
    cfg_check(0, 32'h8000_0004, "R2 readback quad2");

    dp = (32'h105 << 20) | (1 << 18) | (1 << 17) | (1 << 16) | 32'hA5A5;
    cfg_write(1, dp);
    cfg_check(1, dp, "R3 R4 readback armed");

    beat(1, d1, d1, 0, "R9 other quadrant");
    cfg_check(1, dp, "R9 still pending");

    beat(2, d1, corrupt(d1, 9'h105, 16'hA5A5), 1, "R7 R11 inject");
    cfg_check(1, dp & ~(32'h1 << 17), "R8 request cleared");
    beat(2, d2, d2, 0, "R8 no second fire");

    cfg_write(1, (1 << 17) | 32'h00FF);
    cfg_check(1, 32'h0000_00FF, "R5 zero mask");
    cfg_write(1, (1 << 17) | (32'h1 << 20));
    cfg_check(1, 32'h0010_0000, "R5 zero vector");

    cfg_write(0, 32'h8000_0006);
    cfg_check(0, 32'h8000_0006, "R2 readback quad3");
    ecc_enable = 0;
    dp = (32'h0FF << 20) | (1 << 17) | 32'h0001;
    cfg_write(1, dp);
    beat(3, d2, d2, 0, "R10 gated");
    cfg_check(1, dp, "R10 still pending");
    ecc_enable = 1;
    beat(3, d2, corrupt(d2, 9'h0FF, 16'h0001), 1, "R10 R7 fire after enable");

    cfg_write(0, 32'h3000_0006);
    cfg_write(1, (32'h1FF << 20) | (1 << 17) | 32'hFFFF);
    cfg_check(1, 32'h0, "R6 deselected read");
    beat(3, d1, d1, 0, "R6 no arm when deselected");
    cfg_write(0, 32'h8000_0006);
    cfg_check(1, (32'h0FF << 20) | 32'h0001, "R6 state untouched");

    repeat (2) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++; $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule